// File: doc/BRIEF.md
# Reloadable Baud Rate Generator

This block derives the 16x oversampling tick of an asynchronous serial port from the peripheral clock. A fixed divide-by-two prescaler produces an enable pulse on every second clock, and a reload down-counter advances on those pulses. When the counter passes zero it emits a one-clock tick and reloads. The tick period is therefore 2*(R+1) peripheral clocks, where R is the programmed reload value. To obtain a full divisor D, software writes R = D/2 - 1.

The reload value sits in a small register. That register accepts writes only while the run input is low. Software first stops the generator, then writes the new value, then raises run. While run is low, the prescaler phase and the counter are held at their starting point, so the first tick after run rises comes a full period later. A receiver that waits for run before it enables itself therefore sees correctly spaced ticks from the first one. Only the integer path with the divide-by-two prescaler is provided.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, tick is 0 and the reload register holds 0.
- R2: While run is 0, tick stays 0. Dropping run forces tick to 0 from the next clock edge on.
- R3: While run stays 1, rising edges of tick are spaced exactly 2*(R+1) clock cycles apart, where R is the reload register value.
- R4: The first tick after run goes from 0 to 1 is high after exactly 2*(R+1) rising clock edges, counting the first edge that samples run as 1.
- R5: Each tick lasts exactly one clock cycle.
- R6: A write (baud_wr = 1) while run is 0 loads baud_wdata into the reload register. This includes a write in the cycle directly before the edge that first samples run as 1, and that first period already uses the new value.
- R7: A write while run is 1 is ignored. The period stays the same, and it is still the old value after a stop and restart.
- R8: A reload value of 0 gives one tick every 2 clock cycles.
- R9: The all-ones reload value gives a period of 2^(RELOAD_W+1) clock cycles.
- R10: Stopping in the middle of a period and restarting gives a full first period again, measured from the restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Generator enable; reload writes are accepted only while low |
| baud_wr | input | 1 | Write strobe for the reload register |
| baud_wdata | input | RELOAD_W (13) | Reload value, the wanted divisor halved minus one |
| tick | output | 1 | One-cycle oversampling tick |

## Verification
The hardest case to reach is a reload write in the cycle just before the edge that first samples run as 1. In that cycle the register itself has not yet been updated, so the counter must pick up the written value on a bypass path. The directed sequence drives the write at one falling edge and raises run at the very next one, and every period test begins this way. A write while running is placed just after a tick. Its effect, or the lack of one, is then read from the spacing of the following ticks and from the first period after a restart.

// File: rtl/bgen_pkg.sv
package bgen_pkg;

    // Phase of the divide-by-two prescaler.
    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } pre_phase_e;

    // State of the reload counter.
    typedef struct packed {
        logic [31:0] cnt;
        logic        tick;
    } cnt_state_t;

    // Number of peripheral clocks between ticks for a reload value.
    function automatic int unsigned period_clocks(input int unsigned reload);
        return 2 * (reload + 1);
    endfunction

endpackage

// File: rtl/bgen_prescale.sv
module bgen_prescale
    import bgen_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic pulse
);
    pre_phase_e phase_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase_q <= PH_FIRST;
        end else begin
            phase_q <= (phase_q == PH_FIRST) ? PH_SECOND : PH_FIRST;
        end
    end

    // Enable pulse on every second clock while running.
    assign pulse = run && (phase_q == PH_SECOND);

endmodule

// File: rtl/bgen_reload_reg.sv
module bgen_reload_reg #(
    parameter int RELOAD_W = 13
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic                wr,
    input  logic [RELOAD_W-1:0] wdata,
    output logic [RELOAD_W-1:0] reload_q,
    output logic [RELOAD_W-1:0] load_val
);
    logic accept;

    // Writes are taken only while the generator is stopped.
    assign accept = wr && !run;

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '0;
        end else if (accept) begin
            reload_q <= wdata;
        end
    end

    // Bypass path: a write in the last stopped cycle reaches the counter at once.
    assign load_val = accept ? wdata : reload_q;

endmodule

// File: rtl/bgen_down_counter.sv
module bgen_down_counter #(
    parameter int RELOAD_W = 13
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic                pulse,
    input  logic [RELOAD_W-1:0] load_val,
    output logic                tick
);
    logic [RELOAD_W-1:0] cnt_q;
    logic                tick_q;
    logic                at_zero;

    assign at_zero = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else if (!run) begin
            // Hold at the start of a period so a restart gives a full one.
            cnt_q  <= load_val;
            tick_q <= 1'b0;
        end else if (pulse) begin
            if (at_zero) begin
                cnt_q  <= load_val;
                tick_q <= 1'b1;
            end else begin
                cnt_q  <= cnt_q - 1'b1;
                tick_q <= 1'b0;
            end
        end else begin
            tick_q <= 1'b0;
        end
    end

    assign tick = tick_q;

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
    parameter int RELOAD_W = 13
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic                baud_wr,
    input  logic [RELOAD_W-1:0] baud_wdata,
    output logic                tick
);
    logic                pulse;
    logic [RELOAD_W-1:0] reload_q;
    logic [RELOAD_W-1:0] load_val;

    bgen_prescale u_pre (
        .clk   (clk),
        .rst   (rst),
        .run   (run),
        .pulse (pulse)
    );

    bgen_reload_reg #(.RELOAD_W(RELOAD_W)) u_reg (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .wr       (baud_wr),
        .wdata    (baud_wdata),
        .reload_q (reload_q),
        .load_val (load_val)
    );

    bgen_down_counter #(.RELOAD_W(RELOAD_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .pulse    (pulse),
        .load_val (load_val),
        .tick     (tick)
    );

endmodule

// File: rtl/bgen_checker.sv
module bgen_checker #(
    parameter int RELOAD_W = 13
) (
    input logic                clk,
    input logic                rst,
    input logic                run,
    input logic                baud_wr,
    input logic [RELOAD_W-1:0] baud_wdata,
    input logic                tick,
    input logic [RELOAD_W-1:0] reload_q
);
    localparam int GAP_W = RELOAD_W + 2;

    logic [GAP_W-1:0] gap_q;
    logic [GAP_W-1:0] want;

    // Edges since the last tick, or since run was first sampled high.
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            gap_q <= '0;
        end else if (tick) begin
            gap_q <= GAP_W'(1);
        end else begin
            gap_q <= gap_q + GAP_W'(1);
        end
    end

    assign want = ({2'b00, reload_q} + GAP_W'(1)) << 1;

    p_reset_state_r1: assert property (@(posedge clk) rst |=> (!tick && reload_q == '0));

    p_quiet_when_stopped_r2: assert property (@(posedge clk) disable iff (rst)
        !run |=> !tick);

    p_period_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && run) |-> (gap_q == want));

    p_single_cycle_r5: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    p_stopped_write_r6: assert property (@(posedge clk) disable iff (rst)
        (baud_wr && !run) |=> (reload_q == $past(baud_wdata)));

    p_running_write_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (baud_wr && run) |=> $stable(reload_q));

endmodule

bind baud_tick_gen bgen_checker #(.RELOAD_W(RELOAD_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .baud_wr    (baud_wr),
    .baud_wdata (baud_wdata),
    .tick       (tick),
    .reload_q   (reload_q)
);

// File: tb/baud_tick_gen_bench.sv
`timescale 1ns/1ps
module baud_tick_gen_bench;
    localparam int W = 13;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         run = 1'b0;
    logic         baud_wr = 1'b0;
    logic [W-1:0] baud_wdata = '0;
    logic         tick;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    baud_tick_gen #(.RELOAD_W(W)) u_baud_tick_gen (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .baud_wr    (baud_wr),
        .baud_wdata (baud_wdata),
        .tick       (tick)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles, expected under 190000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests = tests + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Count rising edges until tick is seen high at a falling edge.
    task automatic wait_tick(input int limit, output int n);
        n = 0;
        do begin
            @(posedge clk);
            @(negedge clk);
            n = n + 1;
        end while (!tick && n < limit);
    endtask

    // Write while stopped, leaving at the next falling edge with the strobe low.
    task automatic set_reload(input logic [W-1:0] v);
        run = 1'b0;
        baud_wr = 1'b1;
        baud_wdata = v;
        @(negedge clk);
        baud_wr = 1'b0;
    endtask

    task automatic stop_gen();
        run = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        int n;
        check(tick == 1'b0, "R1 tick after reset", int'(tick), 0);
        run = 1'b1;
        wait_tick(20, n);
        check(n == 2, "R1 reload 0 after reset (first period)", n, 2);
        wait_tick(20, n);
        check(n == 2, "R8 reload 0 period", n, 2);
        @(negedge clk);
        check(tick == 1'b0, "R5 tick one cycle at reload 0", int'(tick), 0);
        stop_gen();
    endtask

    task automatic t_stopped_quiet();
        int n;
        int seen = 0;
        set_reload(W'(3));
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (tick) seen = seen + 1;
        end
        check(seen == 0, "R2 no tick while stopped", seen, 0);
        run = 1'b1;
        wait_tick(50, n);
        repeat (3) @(negedge clk);
        run = 1'b0;
        seen = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (tick) seen = seen + 1;
        end
        check(seen == 0, "R2 no tick after run drops", seen, 0);
    endtask

    task automatic t_period(input int v);
        int n;
        int p = 2 * (v + 1);
        set_reload(W'(v));
        run = 1'b1;
        wait_tick(p + 10, n);
        check(n == p, "R4/R6 first period after write then run", n, p);
        @(negedge clk);
        check(tick == 1'b0, "R5 tick lasts one cycle", int'(tick), 0);
        wait_tick(p + 10, n);
        check(n == p - 1, "R3 steady period", n + 1, p);
        wait_tick(p + 10, n);
        check(n == p, "R3 steady period", n, p);
        stop_gen();
    endtask

    task automatic t_write_running();
        int n;
        set_reload(W'(4));
        run = 1'b1;
        wait_tick(30, n);
        baud_wr = 1'b1;
        baud_wdata = W'(9);
        @(negedge clk);
        baud_wr = 1'b0;
        wait_tick(40, n);
        wait_tick(40, n);
        check(n == 10, "R7 running write leaves period", n, 10);
        stop_gen();
        run = 1'b1;
        wait_tick(40, n);
        check(n == 10, "R7 old reload kept after restart", n, 10);
        stop_gen();
    endtask

    task automatic t_restart_midway();
        int n;
        set_reload(W'(6));
        run = 1'b1;
        repeat (5) @(negedge clk);
        stop_gen();
        run = 1'b1;
        wait_tick(40, n);
        check(n == 14, "R10 full first period after restart", n, 14);
        stop_gen();
    endtask

    task automatic t_max();
        int n;
        int p = 1 << (W + 1);
        set_reload({W{1'b1}});
        run = 1'b1;
        wait_tick(p + 10, n);
        check(n == p, "R9 all-ones reload first period", n, p);
        wait_tick(p + 10, n);
        check(n == p, "R9 all-ones reload period", n, p);
        stop_gen();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_stopped_quiet();
        t_period(5);
        t_period(1);
        t_period(0);
        t_write_running();
        t_restart_midway();
        t_max();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule